// File: doc/BRIEF.md
# Byte-Serial Code Memory Programmer with Lock Protection

This block is the programming front end of a small on-chip code store of 2048 bytes, with the store held inside it as a behavioural array. An external programmer selects an operation on a two-bit mode input and fires it with a strobe. The operations are read/verify, byte write, lock write and chip erase. The byte address is not supplied. An internal counter is cleared by a rising edge of an enable input, and each rising edge of a separate step input moves it on by one.

Byte writes and lock writes run for a fixed number of cycles. Chip erase starts only after the strobe has been held high long enough, and then sweeps the whole array to all ones. While any of these runs, a ready output stays low. During a byte write, a read of the byte being written returns the write data with its top bit inverted. Two lock bits give three protection levels. A chip erase is the only way to clear them.

Top module: `fprog_ctrl`

## Requirements
- R1: After reset, ready is 1, the address is 0x000, both lock bits are clear, and dout is 0xFF. The array starts with every byte at 0xFF.
- R2: A rising edge of prog_en clears the address to 0x000. A rising edge of step adds one, and the address wraps from 0x7FF to 0x000. If both edges arrive in the same cycle, the clear wins.
- R3: With mode 2'b01, hv_en high and no lock set, a rising edge of strobe holds ready low for exactly WRITE_CYC cycles. The byte at the current address is then updated.
- R4: A write can only clear bits. The stored result is the old byte AND the write data, so a 0 bit never returns to 1.
- R5: While a byte write runs, dout at the address being written equals the write data with bit 7 inverted. At any other address dout is 0xFF.
- R6: A strobe edge while hv_en is low has no effect. Ready stays 1 and the array is unchanged.
- R7: With mode 2'b10, each strobe edge runs a lock write that holds ready low for WRITE_CYC cycles. The first lock write programs lock bit 1 and the second programs lock bit 2.
- R8: Once lock bit 1 is programmed, byte writes are rejected: ready stays 1 and the array is unchanged. Verify reads still return the stored data.
- R9: Once both lock bits are programmed, verify reads of the array return 0xFF.
- R10: With mode 2'b11, holding strobe high for ERASE_HOLD cycles starts an erase. The erase holds ready low for 2048 cycles, sets every byte to 0xFF and clears both lock bits. Lock bits never clear in any other way.
- R11: If strobe is released before ERASE_HOLD cycles in erase mode, nothing changes and ready stays 1.
- R12: While ready is low, changes on mode and new strobe edges are ignored. The running operation keeps its length and its effect.
- R13: In mode 2'b00 with sig_sel high, dout returns the identification bytes SIG_B0, SIG_B1 and SIG_B2 at addresses 0x000 to 0x002, and 0xFF at any other address. This holds at every lock level. In mode 2'b00 with sig_sel low, dout returns the array byte, two cycles after the address settles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_en | input | 1 | Enable; its rising edge clears the address counter |
| step | input | 1 | Its rising edge advances the address counter |
| hv_en | input | 1 | Programming-voltage enable; required for strobes to act |
| strobe | input | 1 | Program strobe, held high for an erase |
| mode | input | 2 | 00 read, 01 byte write, 10 lock write, 11 erase |
| sig_sel | input | 1 | Selects identification bytes on reads |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data or polling value |
| ready | output | 1 | High when no timed operation runs |

## Verification
The address counter can receive its clear edge and its step edge in the same cycle. The bench raises prog_en and step together on one clock edge after writing distinct bytes at 0x000 and 0x001. It then judges the result by which byte a verify read returns. A second overlap is a new strobe edge, with a changed mode, arriving during a running write. The bench judges that case by the measured busy length and by the data left at the target address and at untouched addresses.

// File: rtl/fp_pkg.sv
package fp_pkg;
  typedef enum logic [1:0] {
    MD_READ  = 2'b00,
    MD_WRITE = 2'b01,
    MD_LOCK  = 2'b10,
    MD_ERASE = 2'b11
  } fp_mode_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_LOCK  = 2'd2,
    OP_ERASE = 2'd3
  } fp_op_e;
endpackage

// File: rtl/fp_addr_ctr.sv
module fp_addr_ctr #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  logic en_q, step_q;
  logic clr_ev, adv_ev;

  assign clr_ev = en & ~en_q;
  assign adv_ev = step & ~step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      step_q <= 1'b0;
      addr   <= '0;
    end else begin
      en_q   <= en;
      step_q <= step;
      if (clr_ev)      addr <= '0;
      else if (adv_ev) addr <= addr + 1'b1;
    end
  end

  AST_ADDR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (en && !en_q) |=> (addr == '0)); // R2
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && !step_q && !(en && !en_q) && (addr == '1)) |=> (addr == '0)); // R2
endmodule

// File: rtl/fp_array.sv
module fp_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fp_seq.sv
module fp_seq
  import fp_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int WRITE_CYC  = 64,
  parameter int ERASE_HOLD = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hv_en,
  input  logic              strobe,
  input  fp_mode_e          mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] rdata,
  output logic              busy,
  output fp_op_e            op,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] poll_addr,
  output logic [DATA_W-1:0] poll_data,
  output logic [1:0]        lock_lvl
);
  localparam int CW = (WRITE_CYC > 2) ? $clog2(WRITE_CYC) : 1;
  localparam int HW = (ERASE_HOLD > 2) ? $clog2(ERASE_HOLD) : 1;

  logic              strobe_q, strobe_rise;
  logic [CW-1:0]     cnt;
  logic              holding;
  logic [HW-1:0]     hold_cnt;
  logic [ADDR_W-1:0] eptr;
  logic              lb1, lb2;

  assign strobe_rise = strobe & ~strobe_q;
  assign lock_lvl    = lb2 ? 2'd2 : (lb1 ? 2'd1 : 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q  <= 1'b0;
      busy      <= 1'b0;
      op        <= OP_IDLE;
      cnt       <= '0;
      holding   <= 1'b0;
      hold_cnt  <= '0;
      eptr      <= '0;
      lb1       <= 1'b0;
      lb2       <= 1'b0;
      poll_addr <= '0;
      poll_data <= '0;
    end else begin
      strobe_q <= strobe;
      if (busy) begin
        if (op == OP_ERASE) begin
          eptr <= eptr + 1'b1;
          if (eptr == '1) begin
            busy <= 1'b0;
            op   <= OP_IDLE;
            lb1  <= 1'b0;
            lb2  <= 1'b0;
          end
        end else if (cnt == '0) begin
          busy <= 1'b0;
          op   <= OP_IDLE;
          if (op == OP_LOCK) begin
            if (!lb1) lb1 <= 1'b1;
            else      lb2 <= 1'b1;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (holding) begin
        if (!(strobe && hv_en)) begin
          holding <= 1'b0;
        end else if (hold_cnt == HW'(ERASE_HOLD - 1)) begin
          holding <= 1'b0;
          busy    <= 1'b1;
          op      <= OP_ERASE;
          eptr    <= '0;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end else if (strobe_rise && hv_en) begin
        case (mode)
          MD_WRITE: begin
            if (!lb1) begin
              busy      <= 1'b1;
              op        <= OP_WRITE;
              cnt       <= CW'(WRITE_CYC - 1);
              poll_addr <= addr;
              poll_data <= din;
            end
          end
          MD_LOCK: begin
            busy <= 1'b1;
            op   <= OP_LOCK;
            cnt  <= CW'(WRITE_CYC - 1);
          end
          MD_ERASE: begin
            holding  <= 1'b1;
            hold_cnt <= HW'(1);
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_addr = busy ? poll_addr : addr;
    wr_en   = 1'b0;
    wr_addr = poll_addr;
    wr_data = rdata & poll_data;
    if (busy && op == OP_ERASE) begin
      wr_en   = 1'b1;
      wr_addr = eptr;
      wr_data = '1;
    end else if (busy && op == OP_WRITE && cnt == '0) begin
      wr_en = 1'b1;
    end
  end

  AST_LOCK_CLEAR_ONLY_ERASE: assert property (@(posedge clk) disable iff (rst)
    (($past(lb1) && !lb1) || ($past(lb2) && !lb2)) |-> ($past(op) == OP_ERASE)); // R10
  AST_OP_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(op)); // R12
  AST_LOCKED_WRITE_REJECT: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(busy) && op == OP_WRITE) |-> ($past(lock_lvl) == 2'd0)); // R8
  AST_LOCK_ORDER: assert property (@(posedge clk) disable iff (rst)
    lb2 |-> lb1); // R7
endmodule

// File: rtl/fprog_ctrl.sv
module fprog_ctrl
  import fp_pkg::*;
#(
  parameter int                ADDR_W     = 11,
  parameter int                DATA_W     = 8,
  parameter int                WRITE_CYC  = 64,
  parameter int                ERASE_HOLD = 256,
  parameter logic [DATA_W-1:0] SIG_B0     = 8'h1E,
  parameter logic [DATA_W-1:0] SIG_B1     = 8'h21,
  parameter logic [DATA_W-1:0] SIG_B2     = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_en,
  input  logic              step,
  input  logic              hv_en,
  input  logic              strobe,
  input  logic [1:0]        mode,
  input  logic              sig_sel,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              ready
);
  logic [ADDR_W-1:0] addr, wr_addr, rd_addr, poll_addr;
  logic [DATA_W-1:0] rdata, wr_data, poll_data, dout_nx;
  logic              busy, wr_en;
  logic [1:0]        lock_lvl;
  fp_op_e            op;
  fp_mode_e          mode_e;

  assign mode_e = fp_mode_e'(mode);
  assign ready  = ~busy;

  fp_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .en(prog_en), .step(step), .addr(addr)
  );

  fp_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .WRITE_CYC(WRITE_CYC), .ERASE_HOLD(ERASE_HOLD)
  ) u_seq (
    .clk(clk), .rst(rst), .hv_en(hv_en), .strobe(strobe), .mode(mode_e),
    .addr(addr), .din(din), .rdata(rdata), .busy(busy), .op(op),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .poll_addr(poll_addr), .poll_data(poll_data), .lock_lvl(lock_lvl)
  );

  fp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rdata)
  );

  always_comb begin
    dout_nx = '1;
    if (busy) begin
      if (op == OP_WRITE && addr == poll_addr)
        dout_nx = {~poll_data[DATA_W-1], poll_data[DATA_W-2:0]};
    end else if (mode_e == MD_READ) begin
      if (sig_sel) begin
        case (addr)
          ADDR_W'(0): dout_nx = SIG_B0;
          ADDR_W'(1): dout_nx = SIG_B1;
          ADDR_W'(2): dout_nx = SIG_B2;
          default:    dout_nx = '1;
        endcase
      end else if (lock_lvl != 2'd2) begin
        dout_nx = rdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '1;
    else     dout <= dout_nx;
  end

  AST_NO_WRITE_WHEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op == OP_WRITE) |-> (lock_lvl == 2'd0)); // R8
  AST_POLL_WHILE_WRITING: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && $past(op) == OP_WRITE && $past(addr) == $past(poll_addr))
      |-> (dout[DATA_W-1] != $past(poll_data[DATA_W-1]))); // R5
endmodule

// File: tb/fprog_ctrl_tb.sv
module fprog_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WCYC  = 64;
  localparam int EHOLD = 256;
  localparam int DEPTH = 2048;

  logic       clk = 1'b0;
  logic       rst, prog_en, step, hv_en, strobe, sig_sel;
  logic [1:0] mode;
  logic [7:0] din, dout;
  logic       ready;

  int n_checks = 0;
  int n_fails  = 0;

  typedef struct { string tag; int exp; } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fprog_ctrl dut_i (
    .clk(clk), .rst(rst), .prog_en(prog_en), .step(step), .hv_en(hv_en),
    .strobe(strobe), .mode(mode), .sig_sel(sig_sel), .din(din),
    .dout(dout), .ready(ready)
  );

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares queued dout expectations
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(it.tag, int'(dout), it.exp);
      end
    end
  end

  task automatic expect_dout(string tag, int exp);
    item_t it;
    it.tag = tag; it.exp = exp;
    q.push_back(it);
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step_n(int n);
    for (int i = 0; i < n; i++) begin
      step = 1'b1; tick(1);
      step = 1'b0; tick(1);
    end
  endtask

  task automatic goto_addr(int a);
    prog_en = 1'b0; tick(1);
    prog_en = 1'b1; tick(1);
    step_n(a);
  endtask

  task automatic read_at(int a, int exp, string tag);
    mode = 2'b00;
    goto_addr(a);
    tick(4);
    expect_dout(tag, exp);
  endtask

  // fires a strobe; returns the number of cycles ready stays low
  task automatic pulse_op(logic [1:0] m, logic [7:0] d, output int busy_cyc);
    mode = m; din = d;
    strobe = 1'b1; tick(1);
    strobe = 1'b0;
    busy_cyc = 0;
    while (ready == 1'b0) begin busy_cyc++; tick(1); end
  endtask

  task automatic erase_hold(int hold, output int busy_cyc);
    mode = 2'b11;
    busy_cyc = 0;
    strobe = 1'b1;
    for (int i = 0; i < hold; i++) begin
      tick(1);
      if (!ready) busy_cyc++;
    end
    strobe = 1'b0;
    tick(1);
    while (ready == 1'b0) begin busy_cyc++; tick(1); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    int bc;
    rst = 1'b1; prog_en = 1'b0; step = 1'b0; hv_en = 1'b1; strobe = 1'b0;
    sig_sel = 1'b0; mode = 2'b00; din = 8'h00;
    tick(3);
    rst = 1'b0;
    tick(2);
    check("R1 ready after reset", int'(ready), 1);
    expect_dout("R1 dout after reset", 8'hFF);

    // R3 basic writes
    goto_addr(0);
    pulse_op(2'b01, 8'hA5, bc);
    check("R3 write busy length", bc, WCYC);
    read_at(0, 8'hA5, "R3 readback addr0");
    goto_addr(1);
    pulse_op(2'b01, 8'h3C, bc);
    read_at(1, 8'h3C, "R3 readback addr1");

    // R2 clear and step in the same cycle: clear wins
    mode = 2'b00;
    goto_addr(1);
    prog_en = 1'b0; tick(1);
    prog_en = 1'b1; step = 1'b1; tick(1);
    step = 1'b0; tick(4);
    expect_dout("R2 clear beats step", 8'hA5);
    // R2 wrap
    step_n(DEPTH); tick(4);
    expect_dout("R2 wrap to 0", 8'hA5);

    // R5 data polling
    goto_addr(5);
    mode = 2'b01; din = 8'h81;
    strobe = 1'b1; tick(1); strobe = 1'b0;
    tick(3);
    expect_dout("R5 polling complement msb", 8'h01);
    step = 1'b1; tick(1); step = 1'b0; tick(3);
    expect_dout("R5 other address during write", 8'hFF);
    while (!ready) tick(1);
    read_at(5, 8'h81, "R5 true data after write");

    // R4 AND behaviour
    goto_addr(5);
    pulse_op(2'b01, 8'h7E, bc);
    read_at(5, 8'h00, "R4 bits only clear");

    // R6 hv_en low
    goto_addr(1);
    hv_en = 1'b0;
    pulse_op(2'b01, 8'h00, bc);
    check("R6 no busy without hv_en", bc, 0);
    hv_en = 1'b1;
    read_at(1, 8'h3C, "R6 data unchanged");

    // R12 strobes and mode changes ignored while busy
    goto_addr(7);
    mode = 2'b01; din = 8'hF0;
    strobe = 1'b1; tick(1); strobe = 1'b0;
    bc = 1;
    mode = 2'b11; strobe = 1'b1; tick(1); bc++; strobe = 1'b0; tick(1); bc++;
    mode = 2'b10; strobe = 1'b1; tick(1); bc++; strobe = 1'b0; tick(1); bc++;
    while (!ready) begin bc++; tick(1); end
    check("R12 busy length unchanged", bc - 1, WCYC);
    read_at(7, 8'hF0, "R12 write kept");
    read_at(0, 8'hA5, "R12 no erase happened");
    goto_addr(8);
    pulse_op(2'b01, 8'h55, bc);
    read_at(8, 8'h55, "R12 no lock happened");

    // R11 early release aborts erase
    erase_hold(EHOLD - 1, bc);
    check("R11 aborted erase not busy", bc, 0);
    read_at(0, 8'hA5, "R11 array unchanged");

    // R7 / R8 first lock
    pulse_op(2'b10, 8'h00, bc);
    check("R7 lock write busy length", bc, WCYC);
    goto_addr(9);
    pulse_op(2'b01, 8'h12, bc);
    check("R8 write rejected", bc, 0);
    read_at(9, 8'hFF, "R8 array unchanged");
    read_at(0, 8'hA5, "R8 verify still allowed");

    // R13 signature
    sig_sel = 1'b1;
    read_at(0, 8'h1E, "R13 sig byte 0");
    read_at(1, 8'h21, "R13 sig byte 1");
    read_at(2, 8'h5A, "R13 sig byte 2");
    read_at(3, 8'hFF, "R13 beyond signature");
    sig_sel = 1'b0;

    // R9 second lock
    pulse_op(2'b10, 8'h00, bc);
    check("R7 second lock busy length", bc, WCYC);
    read_at(0, 8'hFF, "R9 verify blocked");
    sig_sel = 1'b1;
    read_at(1, 8'h21, "R13 sig under full lock");
    sig_sel = 1'b0;

    // R10 full erase
    erase_hold(EHOLD + 3, bc);
    check("R10 erase busy length", bc, DEPTH);
    read_at(7, 8'hFF, "R10 erased addr7");
    goto_addr(0);
    pulse_op(2'b01, 8'h42, bc);
    check("R10 locks cleared, write accepted", bc, WCYC);
    read_at(0, 8'h42, "R10 write after erase");
    read_at(1, 8'hFF, "R10 erased addr1");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule